// File: doc/BRIEF.md
# Serial Management Register Read Master

This block reads one 32-bit word from an external switch device over a two-wire management link: a clock the block generates and a shared data line. The host presents a 7-bit register index, a one-bit table select (configuration registers or internal counters) and a one-cycle start strobe. The block then runs a complete read frame. It shifts out a long run of ones as a preamble, then a 16-bit command, MSB first. It releases the data line for one turnaround clock and clocks in 32 reply bits, MSB first. Two idle clocks close the frame.

The data line is split into an output, an output enable and an input, so a pad or a bench can model the shared wire. A chip-select pin is driven low and enabled for the whole frame. When the frame ends, the clock and select enables drop, and the captured word appears on a data output with a one-cycle valid pulse. The clock high and low phases each last a parameter number of system cycles. This parameter sets how slow the serial clock runs.

Top module: `mgmt_rd_master`

## Requirements
- R1: After reset and between frames, busy_o, rvalid_o, mclk_o and all three output enables are 0.
- R2: The first PRE_BITS (32) serial clock rising edges of a frame see the data line enabled and driving 1, with the select pin enabled and driving 0 for the whole frame.
- R3: The next 16 rising edges carry the command MSB first: bits 15..10 are 110110, bit 9 is the table select (0 configuration, 1 counters), bits 8..7 are 00, and bits 6..0 are the register index. The word equals 16'hD800 | table<<9 | index.
- R4: The data output never changes on a cycle where the serial clock rises, nor while it stays high.
- R5: After the 48 transmitted bits, the data output enable is 0 for every later rising edge of the frame, including exactly one turnaround clock before the reply.
- R6: Reply bits are taken MSB first, one per rising edge number 50 to 81 (counting from 1). Each is sampled on the last system cycle of that clock's high phase.
- R7: A frame has exactly PRE_BITS+16+1+32+2 = 83 rising edges. The clock and select enables drop together with the end of the last high phase.
- R8: rvalid_o is high for exactly one cycle, in the cycle busy_o first reads 0 after the frame. rdata_o then holds the reply until the next frame ends.
- R9: A start strobe while busy_o is 1 is ignored: it changes neither the running frame nor starts another.
- R10: Every low and high phase of the serial clock within a frame lasts exactly HALF_CYC system cycles (the first low phase at least HALF_CYC).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to start a read frame |
| table_i | input | 1 | Table select: 0 configuration, 1 counters |
| reg_idx_i | input | 7 | Register index to read |
| busy_o | output | 1 | Frame in progress |
| rdata_o | output | 32 | Captured reply word |
| rvalid_o | output | 1 | One-cycle pulse marking a new rdata_o |
| mclk_o | output | 1 | Serial clock |
| mclk_oe_o | output | 1 | Serial clock output enable |
| msel_o | output | 1 | Select pin level (low while active) |
| msel_oe_o | output | 1 | Select pin output enable |
| mdo_o | output | 1 | Data line output value |
| mdo_oe_o | output | 1 | Data line output enable |
| mdi_i | input | 1 | Data line input level |

## Verification
The bench builds the block with HALF_CYC = 2. This keeps a frame near 330 cycles, so it can sweep every one of the 128 register indexes with both table values and still check each frame edge by edge. A model of the target captures all 48 outgoing bits and checks the phase lengths and enables. It drives a reply computed from the index and table, with all-zero and all-one replies added. One frame receives an extra start strobe in the middle to show that requests during a frame are dropped.

// File: rtl/mgmt_rd_pkg.sv
package mgmt_rd_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } rd_state_t;

  localparam int CMD_BITS = 16;
  localparam int IDX_W    = 7;

  // Command word: 11 | 01 | 10 | table | 00 | index
  function automatic logic [CMD_BITS-1:0] build_cmd(input logic tbl,
                                                    input logic [IDX_W-1:0] idx);
    logic [CMD_BITS-1:0] w;
    w = {2'b11, 2'b01, 2'b10, tbl, 2'b00, idx};
    return w;
  endfunction

endpackage

// File: rtl/mgmt_rd_phase.sv
module mgmt_rd_phase #(
  parameter int HALF_CYC = 150
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic phase,
  output logic half_end
);
  localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);

  logic [CNT_W-1:0] cnt;

  assign half_end = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (cnt == LAST) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mgmt_rd_seq.sv
module mgmt_rd_seq
  import mgmt_rd_pkg::*;
#(
  parameter int TX_BITS  = 48,
  parameter int RD_FIRST = 49,
  parameter int RD_LAST  = 80,
  parameter int TOTAL    = 83
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic half_end,
  input  logic phase,
  output logic run,
  output logic load,
  output logic clk_end,
  output logic sample,
  output logic last,
  output logic tx_oe,
  output logic pins_oe
);
  localparam int IDX_W_L = $clog2(TOTAL + 1);
  localparam logic [IDX_W_L-1:0] TX_END = IDX_W_L'(TX_BITS - 1);
  localparam logic [IDX_W_L-1:0] R_LO   = IDX_W_L'(RD_FIRST);
  localparam logic [IDX_W_L-1:0] R_HI   = IDX_W_L'(RD_LAST);
  localparam logic [IDX_W_L-1:0] F_END  = IDX_W_L'(TOTAL - 1);

  rd_state_t state;
  logic [IDX_W_L-1:0] idx;

  assign run     = (state == ST_RUN);
  assign load    = start && (state == ST_IDLE);
  assign clk_end = half_end && phase;
  assign sample  = clk_end && (idx >= R_LO) && (idx <= R_HI);
  assign last    = clk_end && (idx == F_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      idx     <= '0;
      tx_oe   <= 1'b0;
      pins_oe <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_RUN;
            idx     <= '0;
            tx_oe   <= 1'b1;
            pins_oe <= 1'b1;
          end
        end
        default: begin
          if (clk_end) begin
            if (idx == F_END) begin
              state   <= ST_IDLE;
              tx_oe   <= 1'b0;
              pins_oe <= 1'b0;
            end else begin
              idx <= idx + 1'b1;
              if (idx == TX_END) tx_oe <= 1'b0;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/mgmt_rd_shift.sv
module mgmt_rd_shift #(
  parameter int TX_BITS   = 48,
  parameter int DATA_BITS = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [TX_BITS-1:0]   tx_word,
  input  logic                 shift_tx,
  input  logic                 sample,
  input  logic                 last,
  input  logic                 mdi,
  output logic                 mdo,
  output logic [DATA_BITS-1:0] rdata,
  output logic                 rvalid
);
  logic [TX_BITS-1:0]   tx_sr;
  logic [DATA_BITS-1:0] rx_sr;

  assign mdo = tx_sr[TX_BITS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr <= '0;
    end else if (load) begin
      tx_sr <= tx_word;
    end else if (shift_tx) begin
      tx_sr <= {tx_sr[TX_BITS-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sr  <= '0;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      if (sample) rx_sr <= {rx_sr[DATA_BITS-2:0], mdi};
      rvalid <= last;
      if (last) rdata <= rx_sr;
    end
  end
endmodule

// File: rtl/mgmt_rd_master.sv
module mgmt_rd_master
  import mgmt_rd_pkg::*;
#(
  parameter int HALF_CYC  = 150,
  parameter int PRE_BITS  = 32,
  parameter int DATA_BITS = 32,
  parameter int IDLE_CLKS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic                 table_i,
  input  logic [IDX_W-1:0]     reg_idx_i,
  output logic                 busy_o,
  output logic [DATA_BITS-1:0] rdata_o,
  output logic                 rvalid_o,
  output logic                 mclk_o,
  output logic                 mclk_oe_o,
  output logic                 msel_o,
  output logic                 msel_oe_o,
  output logic                 mdo_o,
  output logic                 mdo_oe_o,
  input  logic                 mdi_i
);
  localparam int TX_BITS  = PRE_BITS + CMD_BITS;
  localparam int RD_FIRST = TX_BITS + 1;
  localparam int RD_LAST  = RD_FIRST + DATA_BITS - 1;
  localparam int TOTAL    = RD_LAST + 1 + IDLE_CLKS;

  logic run, load, clk_end, sample, last, half_end, phase;
  logic tx_oe, pins_oe;
  logic [TX_BITS-1:0] tx_word;

  assign tx_word = {{PRE_BITS{1'b1}}, build_cmd(table_i, reg_idx_i)};

  mgmt_rd_phase #(.HALF_CYC(HALF_CYC)) u_phase (
    .clk(clk), .rst(rst), .run(run), .phase(phase), .half_end(half_end)
  );

  mgmt_rd_seq #(
    .TX_BITS(TX_BITS), .RD_FIRST(RD_FIRST), .RD_LAST(RD_LAST), .TOTAL(TOTAL)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start_i), .half_end(half_end), .phase(phase),
    .run(run), .load(load), .clk_end(clk_end), .sample(sample), .last(last),
    .tx_oe(tx_oe), .pins_oe(pins_oe)
  );

  mgmt_rd_shift #(.TX_BITS(TX_BITS), .DATA_BITS(DATA_BITS)) u_shift (
    .clk(clk), .rst(rst), .load(load), .tx_word(tx_word), .shift_tx(clk_end),
    .sample(sample), .last(last), .mdi(mdi_i), .mdo(mdo_o),
    .rdata(rdata_o), .rvalid(rvalid_o)
  );

  assign busy_o    = run;
  assign mclk_o    = phase;
  assign mclk_oe_o = pins_oe;
  assign msel_oe_o = pins_oe;
  assign msel_o    = 1'b0;
  assign mdo_oe_o  = tx_oe;
endmodule

// File: rtl/mgmt_rd_chk.sv
module mgmt_rd_chk #(
  parameter int HALF_CYC = 150
) (
  input logic clk,
  input logic rst,
  input logic busy_o,
  input logic rvalid_o,
  input logic mclk_o,
  input logic mclk_oe_o,
  input logic msel_o,
  input logic msel_oe_o,
  input logic mdo_o,
  input logic mdo_oe_o
);
  localparam int HW = $clog2(HALF_CYC + 1) + 1;
  localparam logic [HW-1:0] HMAX = '1;

  logic          mclk_q;
  logic [HW-1:0] hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      mclk_q <= 1'b0;
      hold   <= HMAX;
    end else begin
      mclk_q <= mclk_o;
      if (mclk_o != mclk_q) hold <= '0;
      else if (hold != HMAX) hold <= hold + 1'b1;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy_o && !rvalid_o |-> !mclk_oe_o && !mdo_oe_o && !msel_oe_o);

  p_sel_low_r2: assert property (@(posedge clk) disable iff (rst)
    msel_oe_o |-> !msel_o);

  p_data_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(mclk_o) |-> $stable(mdo_o));

  p_data_high_r4: assert property (@(posedge clk) disable iff (rst)
    mclk_o && $past(mclk_o) |-> $stable(mdo_o));

  p_oe_nest_r5: assert property (@(posedge clk) disable iff (rst)
    mdo_oe_o |-> mclk_oe_o);

  p_end_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> !mclk_oe_o && !mclk_o);

  p_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rvalid_o |=> !rvalid_o);

  p_valid_idle_r8: assert property (@(posedge clk) disable iff (rst)
    rvalid_o |-> !busy_o);

  p_phase_len_r10: assert property (@(posedge clk) disable iff (rst)
    (mclk_o != mclk_q) |-> (hold >= HW'(HALF_CYC - 1)));
endmodule

bind mgmt_rd_master mgmt_rd_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk(clk), .rst(rst), .busy_o(busy_o), .rvalid_o(rvalid_o),
  .mclk_o(mclk_o), .mclk_oe_o(mclk_oe_o), .msel_o(msel_o),
  .msel_oe_o(msel_oe_o), .mdo_o(mdo_o), .mdo_oe_o(mdo_oe_o)
);

// File: tb/tb_mgmt_rd_master.sv
module tb_mgmt_rd_master;
  localparam int HALF  = 2;
  localparam int TOTAL = 83;

  logic clk = 0, rst = 1, start_i = 0, table_i = 0, mdi_i;
  logic [6:0]  reg_idx_i = 0;
  logic busy_o, rvalid_o, mclk_o, mclk_oe_o, msel_o, msel_oe_o, mdo_o, mdo_oe_o;
  logic [31:0] rdata_o;

  always #2.5 clk = ~clk;

  mgmt_rd_master #(.HALF_CYC(HALF)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .table_i(table_i),
    .reg_idx_i(reg_idx_i), .busy_o(busy_o), .rdata_o(rdata_o),
    .rvalid_o(rvalid_o), .mclk_o(mclk_o), .mclk_oe_o(mclk_oe_o),
    .msel_o(msel_o), .msel_oe_o(msel_oe_o), .mdo_o(mdo_o),
    .mdo_oe_o(mdo_oe_o), .mdi_i(mdi_i)
  );

  int errors = 0, checks = 0, cycles = 0;
  logic [31:0] reply = 0;

  // target model state, written only by the monitor
  int rise_cnt = 0, len = 0;
  int bad_tx = 0, bad_rel = 0, bad_stable = 0, bad_len = 0, bad_sel = 0;
  logic [47:0] cmd_cap = 0;
  logic tgt = 1'b1, prev_mclk = 0, prev_mdo = 0, prev_busy = 0;

  assign mdi_i = mdo_oe_o ? mdo_o : tgt;

  always @(negedge clk) begin
    cycles++;
    if (busy_o && !prev_busy) begin
      rise_cnt = 0; cmd_cap = 0; bad_tx = 0; bad_rel = 0;
      bad_stable = 0; bad_len = 0; bad_sel = 0; len = 0; tgt = 1'b1;
    end
    if (mclk_oe_o && (msel_o || !msel_oe_o)) bad_sel++;
    if (mclk_o && prev_mclk && (mdo_o != prev_mdo)) bad_stable++;
    if (mclk_o != prev_mclk) begin
      if (!(mclk_o && rise_cnt == 0) && len != HALF) bad_len++;
      len = 1;
    end else len++;
    if (mclk_o && !prev_mclk) begin
      if (mdo_o != prev_mdo) bad_stable++;
      if (rise_cnt < 48) begin
        cmd_cap = {cmd_cap[46:0], mdo_o};
        if (!mdo_oe_o) bad_tx++;
      end else if (mdo_oe_o) bad_rel++;
      if (rise_cnt >= 49 && rise_cnt <= 80) tgt = reply[31 - (rise_cnt - 49)];
      else tgt = 1'b1;
      rise_cnt++;
    end
    prev_mclk = mclk_o; prev_mdo = mdo_o; prev_busy = busy_o;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rep_of(input int a, input int t);
    return 32'((a * 2 + t + 1) * 32'h9E3779B9);
  endfunction

  task automatic do_frame(input logic [6:0] a, input logic t,
                          input logic [31:0] rep, input bit poke);
    int n;
    logic [15:0] ecmd;
    ecmd = 16'hD800 | (16'(t) << 9) | 16'(a);
    reply = rep;
    @(negedge clk);
    start_i = 1; reg_idx_i = a; table_i = t;
    @(negedge clk);
    start_i = 0; reg_idx_i = ~a; table_i = ~t;
    n = 0;
    while (!rvalid_o && n < 2000) begin
      start_i = (poke && n == 100);
      @(negedge clk);
      n++;
    end
    start_i = 0;
    chk(n < 2000, "R8 watchdog", 64'(n), 64'd2000);
    chk(rdata_o == rep, "R6 reply", 64'(rdata_o), 64'(rep));
    chk(cmd_cap[47:16] == 32'hFFFFFFFF && bad_tx == 0, "R2 preamble",
        64'(cmd_cap[47:16]), 64'hFFFFFFFF);
    chk(cmd_cap[15:0] == ecmd, "R3 command", 64'(cmd_cap[15:0]), 64'(ecmd));
    chk(bad_sel == 0, "R2 select", 64'(bad_sel), 0);
    chk(bad_stable == 0, "R4 data stable", 64'(bad_stable), 0);
    chk(bad_rel == 0, "R5 release", 64'(bad_rel), 0);
    chk(rise_cnt == TOTAL, "R7 edges", 64'(rise_cnt), 64'(TOTAL));
    chk(!mclk_oe_o && !msel_oe_o, "R7 enables off", 64'({mclk_oe_o, msel_oe_o}), 0);
    chk(bad_len == 0, "R10 phase length", 64'(bad_len), 0);
    chk(!busy_o, "R8 busy low", 64'(busy_o), 0);
    @(negedge clk);
    chk(!rvalid_o, "R8 single pulse", 64'(rvalid_o), 0);
    repeat (4) @(negedge clk);
    chk(rdata_o == rep, "R8 hold", 64'(rdata_o), 64'(rep));
    if (poke) begin
      chk(!busy_o && rise_cnt == TOTAL, "R9 start ignored",
          64'(rise_cnt), 64'(TOTAL));
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(!busy_o && !rvalid_o && !mclk_o && !mclk_oe_o && !msel_oe_o && !mdo_oe_o,
        "R1 reset state",
        64'({busy_o, rvalid_o, mclk_o, mclk_oe_o, msel_oe_o, mdo_oe_o}), 0);
    rst = 0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !mclk_oe_o && !mdo_oe_o, "R1 idle after reset",
        64'({busy_o, mclk_oe_o, mdo_oe_o}), 0);
    for (int a = 0; a < 128; a++) begin
      for (int t = 0; t < 2; t++) begin
        do_frame(7'(a), 1'(t), rep_of(a, t), (a == 5 && t == 1));
      end
    end
    do_frame(7'd127, 1'b1, 32'h0000_0000, 1'b0);
    do_frame(7'd0,   1'b0, 32'hFFFF_FFFF, 1'b0);
    do_frame(7'd42,  1'b0, 32'h8000_0001, 1'b1);
    chk(!busy_o && !mclk_oe_o, "R1 idle between frames",
        64'({busy_o, mclk_oe_o}), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 190000);
    errors++; checks++;
    $display("FAIL R7 global watchdog actual=%0d expected<190000", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule